// File: doc/BRIEF.md
# Block Write-Protection Controller

This unit guards program and erase traffic for an eight-block flash array. Each block has two protection bits. A persistent lock bit records whether the block was ever marked as locked. A working protection bit decides whether a program or erase may proceed right now. The controller watches decoded bus writes and recognises four two-write command sequences: protect-load, protect-release, mark-block and erase-unprotected. It updates both sets of bits from these commands.

Whenever the array sequencer asks whether a block may be written, the controller answers on `req_ok` in the same cycle. A request aimed at a protected block raises a sticky violation flag. An erase-unprotected command produces a one-cycle request, together with a mask of the blocks the eraser may touch.

There are two reset inputs. A cold reset returns the persistent bits to a parameter value. A deep power-down wake-up keeps the persistent bits. Both resets leave every block protected until a protect-load command is written.

Top module: `blkprot_ctrl`

## Requirements
- R1: While `por_n` is low at a clock edge, every working bit becomes protected, every persistent bit takes `LOCK_INIT` (default all clear), and `cmd_err`, `prot_err` and `erall_req` are cleared.
- R2: While `dpd_n` is low at a clock edge, every working bit becomes protected and `cmd_err` and `prot_err` clear. The persistent bits keep their values.
- R3: Protect-load is the data byte 57h followed by D0h. The second write must carry an address whose bits 9:8 are 0 and whose bits 7:0 are all 1; higher bits are ignored. It copies every persistent bit into the working bits at the confirming edge.
- R4: Protect-release is the data byte 47h followed by D0h at the same confirm address as in R3. It clears every working bit, so all blocks become writable.
- R5: Mark-block is the data byte 77h followed by D0h. The block index is taken from the top three address bits of the second write (bits 17:15 by default), and the command sets that block's persistent bit. It takes effect only if a protect-release has been confirmed since the last reset or protect-load.
- R6: A mark-block command leaves the working bits unchanged. The new bit becomes active only at the next protect-load.
- R7: Erase-unprotected is the data byte A7h followed by D0h at any address. In the cycle after the confirming edge, `erall_req` is high for exactly one cycle. In that cycle `erall_mask` bit b is 1 exactly when block b's working bit is clear.
- R8: A second write that does not match drops the sequence with no effect and sets the sticky `cmd_err` flag. This covers data other than D0h, a protect-load or protect-release confirm at a wrong address, and a mark-block while release has not been confirmed.
- R9: `req_ok` is 1 exactly when the working bit of block `req_blk` is clear. A cycle with `req_valid` high on a protected block sets the sticky `prot_err` flag.
- R10: A first write whose data is not 57h, 47h, 77h or A7h is ignored, and this includes a stray D0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold power-up reset, active low, synchronous |
| dpd_n | input | 1 | Deep power-down wake-up reset, active low, synchronous |
| wr_en | input | 1 | Decoded bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data byte |
| req_valid | input | 1 | Program or erase attempt on `req_blk` |
| req_blk | input | BLK_W | Block index queried |
| req_ok | output | 1 | Queried block is currently writable |
| erall_req | output | 1 | One-cycle erase-unprotected request |
| erall_mask | output | NBLK | Blocks the eraser may clear |
| cmd_err | output | 1 | Sticky command sequence error |
| prot_err | output | 1 | Sticky protection violation |

## Verification
A wrong working bit is visible on `req_ok` as soon as that block is selected. The check sweeps every block index after each command, so a corrupted bit shows up within the same cycle. A wrong persistent bit stays hidden until the next protect-load copies it across, so every test of the persistent bits ends with a protect-load followed by a sweep. A decoder that is left in the confirm state, or that is wrongly reset, shows up one write later as a missing action or as a `cmd_err` that appears or fails to appear.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;

    localparam logic [7:0] OP_PSET    = 8'h57;
    localparam logic [7:0] OP_PREL    = 8'h47;
    localparam logic [7:0] OP_MARK    = 8'h77;
    localparam logic [7:0] OP_ERALL   = 8'hA7;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONF = 1'b1
    } seq_e;

    typedef enum logic [1:0] {
        PEND_PSET  = 2'd0,
        PEND_PREL  = 2'd1,
        PEND_MARK  = 2'd2,
        PEND_ERALL = 2'd3
    } pend_e;

endpackage

// File: rtl/blkprot_seq.sv
module blkprot_seq
    import blkprot_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BLK_W  = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              dpd_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              unprot,
    output logic              go_pset,
    output logic              go_prel,
    output logic              go_mark,
    output logic              go_erall,
    output logic [BLK_W-1:0]  mark_idx,
    output logic              seq_err
);

    typedef struct packed {
        seq_e  st;
        pend_e pend;
    } seq_t;

    seq_t seq_d, seq_q;
    logic conf_data_ok;
    logic conf_addr_ok;
    logic addr_unused;

    assign conf_data_ok = (wr_data == OP_CONFIRM);
    assign conf_addr_ok = (wr_addr[9:8] == 2'b00) && (&wr_addr[7:0]);
    assign mark_idx     = wr_addr[ADDR_W-1 -: BLK_W];
    assign addr_unused  = ^wr_addr;

    always_comb begin
        seq_d    = seq_q;
        go_pset  = 1'b0;
        go_prel  = 1'b0;
        go_mark  = 1'b0;
        go_erall = 1'b0;
        seq_err  = 1'b0;
        if (wr_en) begin
            if (seq_q.st == SEQ_IDLE) begin
                unique case (wr_data)
                    OP_PSET:  begin seq_d.st = SEQ_CONF; seq_d.pend = PEND_PSET;  end
                    OP_PREL:  begin seq_d.st = SEQ_CONF; seq_d.pend = PEND_PREL;  end
                    OP_MARK:  begin seq_d.st = SEQ_CONF; seq_d.pend = PEND_MARK;  end
                    OP_ERALL: begin seq_d.st = SEQ_CONF; seq_d.pend = PEND_ERALL; end
                    default:  seq_d = seq_q;
                endcase
            end else begin
                seq_d.st = SEQ_IDLE;
                unique case (seq_q.pend)
                    PEND_PSET:  if (conf_data_ok && conf_addr_ok) go_pset = 1'b1;
                                else seq_err = 1'b1;
                    PEND_PREL:  if (conf_data_ok && conf_addr_ok) go_prel = 1'b1;
                                else seq_err = 1'b1;
                    PEND_MARK:  if (conf_data_ok && unprot) go_mark = 1'b1;
                                else seq_err = 1'b1;
                    PEND_ERALL: if (conf_data_ok) go_erall = 1'b1;
                                else seq_err = 1'b1;
                    default:    seq_err = 1'b1;
                endcase
            end
        end
        if (!por_n || !dpd_n) begin
            seq_d.st   = SEQ_IDLE;
            seq_d.pend = PEND_PSET;
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!por_n || !dpd_n)
        $onehot0({go_pset, go_prel, go_mark, go_erall, seq_err})); // R8
    AST_MARK_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!por_n || !dpd_n)
        go_mark |-> unprot); // R5
    AST_ACTION_ON_CONFIRM: assert property (@(posedge clk) disable iff (!por_n || !dpd_n)
        (go_pset || go_prel || go_mark || go_erall) |-> (wr_en && wr_data == OP_CONFIRM)); // R3

endmodule

// File: rtl/blkprot_bits.sv
module blkprot_bits #(
    parameter int              NBLK      = 8,
    parameter int              BLK_W     = 3,
    parameter logic [NBLK-1:0] LOCK_INIT = '0
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             dpd_n,
    input  logic             go_pset,
    input  logic             go_prel,
    input  logic             go_mark,
    input  logic             go_erall,
    input  logic [BLK_W-1:0] mark_idx,
    input  logic             seq_err,
    input  logic             req_valid,
    input  logic [BLK_W-1:0] req_blk,
    output logic             req_ok,
    output logic             unprot,
    output logic             erall_req,
    output logic [NBLK-1:0]  erall_mask,
    output logic             cmd_err,
    output logic             prot_err
);

    typedef struct packed {
        logic [NBLK-1:0] stored;
        logic [NBLK-1:0] active;
        logic            unprot;
        logic            erall;
        logic [NBLK-1:0] mask;
        logic            cerr;
        logic            perr;
    } bits_t;

    bits_t bits_d, bits_q;

    always_comb begin
        bits_d       = bits_q;
        bits_d.erall = 1'b0;
        if (go_pset) begin
            bits_d.active = bits_q.stored;
            bits_d.unprot = 1'b0;
        end
        if (go_prel) begin
            bits_d.active = '0;
            bits_d.unprot = 1'b1;
        end
        if (go_mark) begin
            bits_d.stored[mark_idx] = 1'b1;
        end
        if (go_erall) begin
            bits_d.erall = 1'b1;
            bits_d.mask  = ~bits_q.active;
        end
        if (seq_err) begin
            bits_d.cerr = 1'b1;
        end
        if (req_valid && bits_q.active[req_blk]) begin
            bits_d.perr = 1'b1;
        end
        if (!dpd_n) begin
            bits_d.active = '1;
            bits_d.unprot = 1'b0;
            bits_d.erall  = 1'b0;
            bits_d.mask   = '0;
            bits_d.cerr   = 1'b0;
            bits_d.perr   = 1'b0;
        end
        if (!por_n) begin
            bits_d        = '0;
            bits_d.stored = LOCK_INIT;
            bits_d.active = '1;
        end
    end

    always_ff @(posedge clk) begin
        bits_q <= bits_d;
    end

    assign req_ok     = ~bits_q.active[req_blk];
    assign unprot     = bits_q.unprot;
    assign erall_req  = bits_q.erall;
    assign erall_mask = bits_q.mask;
    assign cmd_err    = bits_q.cerr;
    assign prot_err   = bits_q.perr;

    AST_WAKE_ALL_PROTECTED: assert property (@(posedge clk) disable iff (!por_n)
        !dpd_n |=> (&bits_q.active)); // R2
    AST_MARK_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!por_n || !dpd_n)
        (go_mark && !go_pset && !go_prel) |=> $stable(bits_q.active)); // R6
    AST_RELEASE_OPENS: assert property (@(posedge clk) disable iff (!por_n || !dpd_n)
        go_prel |=> (bits_q.active == '0)); // R4
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!por_n || !dpd_n)
        go_pset |=> (bits_q.active == bits_q.stored)); // R3
    AST_ERALL_SINGLE: assert property (@(posedge clk) disable iff (!por_n || !dpd_n)
        erall_req |=> !erall_req); // R7
    AST_ERALL_MASK: assert property (@(posedge clk) disable iff (!por_n || !dpd_n)
        erall_req |-> (erall_mask == ~bits_q.active)); // R7
    AST_VIOLATION_STICKS: assert property (@(posedge clk) disable iff (!por_n || !dpd_n)
        (req_valid && !req_ok) |=> prot_err); // R9

endmodule

// File: rtl/blkprot_ctrl.sv
module blkprot_ctrl #(
    parameter int              NBLK      = 8,
    parameter int              ADDR_W    = 18,
    parameter logic [NBLK-1:0] LOCK_INIT = '0,
    localparam int             BLK_W     = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              dpd_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              req_valid,
    input  logic [BLK_W-1:0]  req_blk,
    output logic              req_ok,
    output logic              erall_req,
    output logic [NBLK-1:0]   erall_mask,
    output logic              cmd_err,
    output logic              prot_err
);

    logic             go_pset;
    logic             go_prel;
    logic             go_mark;
    logic             go_erall;
    logic             seq_err;
    logic             unprot;
    logic [BLK_W-1:0] mark_idx;

    blkprot_seq #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W)
    ) u_seq (
        .clk      (clk),
        .por_n    (por_n),
        .dpd_n    (dpd_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .unprot   (unprot),
        .go_pset  (go_pset),
        .go_prel  (go_prel),
        .go_mark  (go_mark),
        .go_erall (go_erall),
        .mark_idx (mark_idx),
        .seq_err  (seq_err)
    );

    blkprot_bits #(
        .NBLK      (NBLK),
        .BLK_W     (BLK_W),
        .LOCK_INIT (LOCK_INIT)
    ) u_bits (
        .clk        (clk),
        .por_n      (por_n),
        .dpd_n      (dpd_n),
        .go_pset    (go_pset),
        .go_prel    (go_prel),
        .go_mark    (go_mark),
        .go_erall   (go_erall),
        .mark_idx   (mark_idx),
        .seq_err    (seq_err),
        .req_valid  (req_valid),
        .req_blk    (req_blk),
        .req_ok     (req_ok),
        .unprot     (unprot),
        .erall_req  (erall_req),
        .erall_mask (erall_mask),
        .cmd_err    (cmd_err),
        .prot_err   (prot_err)
    );

    AST_COLD_PROTECTED: assert property (@(posedge clk)
        !por_n |=> (!req_ok && !cmd_err && !prot_err && !erall_req)); // R1

endmodule

// File: tb/blkprot_ctrl_tb.sv
`timescale 1ns/1ps
module blkprot_ctrl_tb;

    localparam int NBLK   = 8;
    localparam int ADDR_W = 18;
    localparam int BLK_W  = 3;
    localparam logic [ADDR_W-1:0] CONF_A = 18'h000FF;

    typedef struct {
        int         kind;
        int         idx;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              dpd_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              req_valid = 1'b0;
    logic [BLK_W-1:0]  req_blk = '0;
    logic              req_ok;
    logic              erall_req;
    logic [NBLK-1:0]   erall_mask;
    logic              cmd_err;
    logic              prot_err;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    item_t exp_q[$];
    event  ev_push;

    always #10 clk = ~clk;

    blkprot_ctrl u_dut (
        .clk        (clk),
        .por_n      (por_n),
        .dpd_n      (dpd_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .req_valid  (req_valid),
        .req_blk    (req_blk),
        .req_ok     (req_ok),
        .erall_req  (erall_req),
        .erall_mask (erall_mask),
        .cmd_err    (cmd_err),
        .prot_err   (prot_err)
    );

    // monitor: compares each expected item against the ports
    initial begin
        forever begin
            @(ev_push);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    0:       act = {7'd0, req_ok};
                    1:       act = {7'd0, erall_req};
                    2:       act = erall_mask;
                    3:       act = {7'd0, cmd_err};
                    default: act = {7'd0, prot_err};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                             it.tag, it.kind, it.idx, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input int idx, input logic [7:0] e, input string tag);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        -> ev_push;
        #0.5;
    endtask

    task automatic bus_wr(input logic [7:0] d, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00; wr_addr = '0;
    endtask

    task automatic cmd2(input logic [7:0] op, input logic [7:0] d, input logic [ADDR_W-1:0] a);
        bus_wr(op, '0);
        bus_wr(d, a);
    endtask

    // expected protection vector: bit b = 1 means block b protected
    task automatic chk_prot(input logic [NBLK-1:0] prot, input string tag);
        for (int b = 0; b < NBLK; b++) begin
            req_blk = BLK_W'(b);
            #0.5;
            push(0, b, {7'd0, ~prot[b]}, tag);
        end
        req_blk = '0;
    endtask

    task automatic pulse_dpd();
        @(negedge clk); dpd_n = 1'b0;
        @(negedge clk); dpd_n = 1'b1;
    endtask

    task automatic attempt(input int b);
        @(negedge clk); req_valid = 1'b1; req_blk = BLK_W'(b);
        @(negedge clk); req_valid = 1'b0; req_blk = '0;
    endtask

    function automatic logic [ADDR_W-1:0] blk_addr(input int b);
        return ADDR_W'(b) << (ADDR_W - BLK_W);
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; dpd_n = 1'b1;
        @(negedge clk);
        // R1: cold reset state
        chk_prot(8'hFF, "R1 cold protected");
        push(3, 0, 8'h00, "R1 cmd_err clear");
        push(4, 0, 8'h00, "R1 prot_err clear");
        push(1, 0, 8'h00, "R1 no erase request");

        // R10: unknown first writes and a stray confirm are ignored
        bus_wr(8'h40, '0);
        bus_wr(8'hD0, CONF_A);
        push(3, 0, 8'h00, "R10 no error");
        chk_prot(8'hFF, "R10 no change");

        // R3: protect-load with high address bits set copies stored (all clear)
        cmd2(8'h57, 8'hD0, 18'h300FF);
        chk_prot(8'h00, "R3 load copies");

        // R5/R8: mark without release is refused
        cmd2(8'h77, 8'hD0, blk_addr(5));
        push(3, 0, 8'h01, "R5 mark refused err");

        // R2: wake-up protects all, clears flags
        pulse_dpd();
        chk_prot(8'hFF, "R2 wake protected");
        push(3, 0, 8'h00, "R2 cmd_err cleared");

        // R4: release
        cmd2(8'h47, 8'hD0, CONF_A);
        chk_prot(8'h00, "R4 release opens");

        // R6: marks do not touch working bits
        cmd2(8'h77, 8'hD0, blk_addr(3));
        cmd2(8'h77, 8'hD0, blk_addr(6));
        chk_prot(8'h00, "R6 working unchanged");
        push(3, 0, 8'h00, "R5 mark accepted");

        // R3/R5: load activates marks; block 5 never marked
        cmd2(8'h57, 8'hD0, CONF_A);
        chk_prot(8'h48, "R3 load after marks");

        // R9: violations
        attempt(4);
        push(4, 0, 8'h00, "R9 allowed block");
        attempt(3);
        push(4, 0, 8'h01, "R9 protected block");

        // R7: erase-unprotected at arbitrary address
        cmd2(8'hA7, 8'hD0, 18'h12345);
        push(1, 0, 8'h01, "R7 erase pulse");
        push(2, 0, 8'hB7, "R7 erase mask");
        @(negedge clk);
        push(1, 0, 8'h00, "R7 pulse one cycle");

        // R2: wake-up keeps stored bits
        pulse_dpd();
        push(4, 0, 8'h00, "R2 prot_err cleared");
        chk_prot(8'hFF, "R2 wake protected again");
        cmd2(8'h57, 8'hD0, CONF_A);
        chk_prot(8'h48, "R2 stored kept");

        // R8: bad confirm address (bit 8)
        pulse_dpd();
        cmd2(8'h57, 8'hD0, 18'h001FF);
        push(3, 0, 8'h01, "R8 bad addr err");
        chk_prot(8'hFF, "R8 bad addr no load");
        // R8: bad confirm data
        pulse_dpd();
        cmd2(8'h57, 8'hAA, CONF_A);
        push(3, 0, 8'h01, "R8 bad data err");
        chk_prot(8'hFF, "R8 bad data no load");
        // R8: release with bit 9 set, then normal load
        pulse_dpd();
        cmd2(8'h47, 8'hD0, 18'h002FF);
        push(3, 0, 8'h01, "R8 release bad addr err");
        chk_prot(8'hFF, "R8 release refused");
        cmd2(8'h57, 8'hD0, CONF_A);
        chk_prot(8'h48, "R3 load after error");
        // R8: erase with wrong confirm
        pulse_dpd();
        cmd2(8'hA7, 8'h00, CONF_A);
        push(1, 0, 8'h00, "R8 erase cancelled");
        push(3, 0, 8'h01, "R8 erase err");

        // R1: cold reset clears stored bits
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        chk_prot(8'hFF, "R1 cold protected again");
        push(3, 0, 8'h00, "R1 cmd_err cleared");
        cmd2(8'h57, 8'hD0, CONF_A);
        chk_prot(8'h00, "R1 stored reset");

        @(negedge clk);
        done = 1'b1;
        summary();
    end

endmodule